// File: doc/BRIEF.md
# Manchester Word Encoder with Sync

This block turns one 16-bit word into a framed Manchester II stream for a twisted-pair or fibre party line. The only clock is the send clock, which runs at twice the bit rate, so each send-clock cycle is one half-bit on the line. From it the block makes a shift clock at the bit rate and exports it. An external serial source uses that shift clock, together with a request strobe, to hand over the data bits one at a time. The block does not hold the word in parallel form.

A frame lasts 20 bit times. It opens with a three-bit-time sync character whose polarity marks the frame as a command word or a data word. Sixteen Manchester-coded data bits follow, most significant bit first. The frame closes with one odd-parity bit. While the enable stays high, frames follow one another with no gap. An inhibit input idles the line driver without disturbing the sequence. A synchronous master reset aborts a frame at any point.

Top module: `manch_word_enc`

## Requirements
- R1: `shift_clk_o` reads 1 in the first cycle after reset and then toggles on every send-clock cycle. Its rising edge marks a bit boundary and its falling edge marks mid-bit.
- R2: A frame starts only when `enc_en_i` is high at a falling shift-clock edge while the block is idle or in the parity slot. The first sync half-bit appears in the send-clock cycle that follows the next rising shift-clock edge. While idle, both line outputs read 1.
- R3: `sync_cmd_i` is sampled at the rising shift-clock edge that opens the frame. When it is 1, the line is positive for three half-bits and then negative for three half-bits. When it is 0, the order is reversed.
- R4: `send_data_o` is high for exactly 16 shift-clock periods per frame, covering bit slots 2 through 17, where slot 0 is the first sync slot.
- R5: `ser_data_i` is sampled only at the rising shift-clock edges that close slots 2 to 17. The bit sampled after slot 2+k is sent in slot 3+k, and the first bit sampled is word bit 15. A one is sent as a positive half-bit followed by a negative half-bit, and a zero as the reverse.
- R6: Slot 19 carries the parity bit. Its value makes the count of ones over the 16 data bits and the parity bit odd. It is coded like a data bit.
- R7: If `enc_en_i` is high at the mid-bit edge of slot 19, slot 0 of the next frame follows directly. Otherwise the line goes idle after slot 19.
- R8: While `drive_en_i` is 0, both line outputs read 1. Frame timing, the request strobe and the bits on the line once `drive_en_i` returns are unchanged.
- R9: While `rst` is 1 at a send-clock edge, the frame is cleared: both line outputs read 1, `send_data_o` reads 0 and `shift_clk_o` reads 1. A frame started after reset is complete and correct.
- R10: A positive line is shown by `line_pos_n_o` = 0 and a negative line by `line_neg_n_o` = 0. The two outputs never read 0 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Send clock at twice the bit rate |
| rst | input | 1 | Master reset, synchronous, active high |
| enc_en_i | input | 1 | Frame request, checked at falling shift-clock edges |
| sync_cmd_i | input | 1 | 1 selects the command sync, 0 selects the data sync |
| ser_data_i | input | 1 | Serial data from the external source |
| drive_en_i | input | 1 | 0 forces both line outputs to idle |
| shift_clk_o | output | 1 | Bit-rate shift clock for the data source |
| send_data_o | output | 1 | Request strobe for the 16 data bits |
| line_pos_n_o | output | 1 | Active-low positive-sense driver control |
| line_neg_n_o | output | 1 | Active-low negative-sense driver control |

## Verification
The bench builds the block with its default width of 16 data bits. At that width a 40-half-bit frame is short enough to compare half-bit by half-bit against a frame built from the requirements. Random words cover both parity outcomes and both sync types, and chains of up to three frames exercise the gap-free hand-over. Directed runs cover all-zero and all-one words, an inhibit window that cuts across the sync and the data, and an abort in the middle of the data field.

// File: rtl/mwe_pkg.sv
package mwe_pkg;

    // Bit times taken by the sync character.
    localparam int SYNC_SLOTS = 3;

    typedef enum logic [1:0] {
        LN_IDLE = 2'd0,
        LN_POS  = 2'd1,
        LN_NEG  = 2'd2
    } line_e;

    // Frame state passed from the sequencer to the line former.
    typedef struct packed {
        logic busy;
        logic cmd;
        logic bit_q;
        logic req;
    } frame_st_t;

    // Sync polarity: the command sync is positive in its first half.
    function automatic logic sync_high(input logic cmd, input logic first_part);
        return cmd ? first_part : !first_part;
    endfunction

    // Parity bit that makes the total count of ones odd.
    function automatic logic odd_fill(input logic even_acc);
        return ~even_acc;
    endfunction

endpackage

// File: rtl/mwe_phase_gen.sv
module mwe_phase_gen (
    input  logic clk,
    input  logic rst,
    output logic ph_o,
    output logic mid_tick_o,
    output logic bnd_tick_o
);

    logic ph_q;

    // ph_q = 0 in the first half of a bit, 1 in the second half.
    always_ff @(posedge clk) begin
        if (rst) ph_q <= 1'b0;
        else     ph_q <= ~ph_q;
    end

    assign ph_o       = ph_q;
    assign mid_tick_o = ~ph_q;  // the coming edge is a falling shift-clock edge
    assign bnd_tick_o = ph_q;   // the coming edge is a rising shift-clock edge

    // R1: the phase alternates on every cycle once reset has been released.
    p_phase_alt_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (ph_q != $past(ph_q)));

endmodule

// File: rtl/mwe_frame_ctrl.sv
module mwe_frame_ctrl
    import mwe_pkg::*;
#(
    parameter int DATA_BITS = 16,
    parameter int SLOT_W    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mid_tick_i,
    input  logic              bnd_tick_i,
    input  logic              en_i,
    input  logic              sync_cmd_i,
    input  logic              ser_i,
    output frame_st_t         st_o,
    output logic [SLOT_W-1:0] slot_o
);

    localparam int WORD_SLOTS = SYNC_SLOTS + DATA_BITS + 1;
    localparam logic [SLOT_W-1:0] FIRST_REQ = SLOT_W'(SYNC_SLOTS - 1);
    localparam logic [SLOT_W-1:0] LAST_REQ  = SLOT_W'(SYNC_SLOTS + DATA_BITS - 2);
    localparam logic [SLOT_W-1:0] PAR_LOAD  = SLOT_W'(SYNC_SLOTS + DATA_BITS - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WORD_SLOTS - 1);
    localparam logic [SLOT_W-1:0] SYNC_END  = SLOT_W'(SYNC_SLOTS);

    logic              busy_q;
    logic              armed_q;
    logic              cmd_q;
    logic              bit_q;
    logic              par_q;
    logic [SLOT_W-1:0] slot_q;

    logic in_req;
    logic at_last;
    logic at_par_load;

    always_comb begin
        in_req      = busy_q && (slot_q >= FIRST_REQ) && (slot_q <= LAST_REQ);
        at_last     = busy_q && (slot_q == LAST_SLOT);
        at_par_load = busy_q && (slot_q == PAR_LOAD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            armed_q <= 1'b0;
            cmd_q   <= 1'b0;
            bit_q   <= 1'b0;
            par_q   <= 1'b0;
            slot_q  <= '0;
        end else begin
            // Falling shift-clock edge: take a request when free to do so.
            if (mid_tick_i && (!busy_q || at_last) && en_i) begin
                armed_q <= 1'b1;
            end
            // Rising shift-clock edge: advance the frame.
            if (bnd_tick_i) begin
                if (armed_q) begin
                    busy_q  <= 1'b1;
                    armed_q <= 1'b0;
                    slot_q  <= '0;
                    cmd_q   <= sync_cmd_i;
                    par_q   <= 1'b0;
                end else if (at_last) begin
                    busy_q <= 1'b0;
                    slot_q <= '0;
                end else if (busy_q) begin
                    slot_q <= slot_q + 1'b1;
                end

                if (in_req) begin
                    bit_q <= ser_i;
                    par_q <= par_q ^ ser_i;
                end else if (at_par_load) begin
                    bit_q <= odd_fill(par_q);
                end
            end
        end
    end

    always_comb begin
        st_o.busy  = busy_q;
        st_o.cmd   = cmd_q;
        st_o.bit_q = bit_q;
        st_o.req   = in_req;
        slot_o     = slot_q;
    end

    // R2: a frame begins only from a request taken at a falling edge.
    p_start_armed_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> ($past(armed_q) && $past(bnd_tick_i)));

    // R3: the sync type stays fixed while the sync character is on the line.
    p_sync_latched_r3: assert property (@(posedge clk) disable iff (rst)
        (busy_q && slot_q != '0 && slot_q < SYNC_END) |-> $stable(cmd_q));

    // R4: the request covers whole shift-clock periods.
    p_req_whole_r4: assert property (@(posedge clk) disable iff (rst)
        (st_o.req && mid_tick_i) |=> st_o.req);

    // R6: in the parity slot the bit on the line completes odd parity.
    p_parity_slot_r6: assert property (@(posedge clk) disable iff (rst)
        at_last |-> (bit_q == odd_fill(par_q)));

    // R7: a request taken in the parity slot opens the next frame at once.
    p_gap_free_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(at_last) && $past(bnd_tick_i) && $past(armed_q)) |-> (busy_q && slot_q == '0));

endmodule

// File: rtl/mwe_line_former.sv
module mwe_line_former
    import mwe_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  frame_st_t         st_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              ph_i,
    input  logic              drive_en_i,
    output logic              pos_n_o,
    output logic              neg_n_o
);

    localparam logic [SLOT_W-1:0] SYNC_END = SLOT_W'(SYNC_SLOTS);
    localparam logic [SLOT_W:0]   SYNC_MID = (SLOT_W + 1)'(SYNC_SLOTS);

    logic [SLOT_W:0] half_idx;
    line_e           ln;

    always_comb begin
        half_idx = {slot_i, ph_i};
        if (!st_i.busy) begin
            ln = LN_IDLE;
        end else if (slot_i < SYNC_END) begin
            ln = sync_high(st_i.cmd, half_idx < SYNC_MID) ? LN_POS : LN_NEG;
        end else begin
            ln = (st_i.bit_q ^ ph_i) ? LN_POS : LN_NEG;
        end
        pos_n_o = !(drive_en_i && (ln == LN_POS));
        neg_n_o = !(drive_en_i && (ln == LN_NEG));
    end

endmodule

// File: rtl/manch_word_enc.sv
module manch_word_enc
    import mwe_pkg::*;
#(
    parameter int DATA_BITS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic enc_en_i,
    input  logic sync_cmd_i,
    input  logic ser_data_i,
    input  logic drive_en_i,
    output logic shift_clk_o,
    output logic send_data_o,
    output logic line_pos_n_o,
    output logic line_neg_n_o
);

    localparam int WORD_SLOTS = SYNC_SLOTS + DATA_BITS + 1;
    localparam int SLOT_W     = $clog2(WORD_SLOTS);

    logic              ph;
    logic              mid_tick;
    logic              bnd_tick;
    frame_st_t         st;
    logic [SLOT_W-1:0] slot;

    mwe_phase_gen u_phase (
        .clk       (clk),
        .rst       (rst),
        .ph_o      (ph),
        .mid_tick_o(mid_tick),
        .bnd_tick_o(bnd_tick)
    );

    mwe_frame_ctrl #(
        .DATA_BITS(DATA_BITS),
        .SLOT_W   (SLOT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mid_tick_i(mid_tick),
        .bnd_tick_i(bnd_tick),
        .en_i      (enc_en_i),
        .sync_cmd_i(sync_cmd_i),
        .ser_i     (ser_data_i),
        .st_o      (st),
        .slot_o    (slot)
    );

    mwe_line_former #(
        .SLOT_W(SLOT_W)
    ) u_line (
        .st_i      (st),
        .slot_i    (slot),
        .ph_i      (ph),
        .drive_en_i(drive_en_i),
        .pos_n_o   (line_pos_n_o),
        .neg_n_o   (line_neg_n_o)
    );

    assign shift_clk_o = ~ph;
    assign send_data_o = st.req;

    // R10: the two driver controls are never active together.
    p_never_both_r10: assert property (@(posedge clk) disable iff (rst)
        !(!line_pos_n_o && !line_neg_n_o));

    // R8: inhibit leaves the line idle.
    p_inhibit_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !drive_en_i |-> (line_pos_n_o && line_neg_n_o));

    // R2: no frame in progress means an idle line.
    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !st.busy |-> (line_pos_n_o && line_neg_n_o && !send_data_o));

endmodule

// File: tb/test_manch_word_enc.sv
module test_manch_word_enc;

    localparam int NB = 16;
    localparam int HF = 2 * (NB + 4);  // half-bits per frame

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enc_en_i = 1'b0;
    logic sync_cmd_i = 1'b0;
    logic ser_data_i = 1'b0;
    logic drive_en_i = 1'b1;
    logic shift_clk_o, send_data_o, line_pos_n_o, line_neg_n_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [NB-1:0] wq [4];
    bit            cq [4];

    always #5 clk = ~clk;

    manch_word_enc i_manch_word_enc (
        .clk         (clk),
        .rst         (rst),
        .enc_en_i    (enc_en_i),
        .sync_cmd_i  (sync_cmd_i),
        .ser_data_i  (ser_data_i),
        .drive_en_i  (drive_en_i),
        .shift_clk_o (shift_clk_o),
        .send_data_o (send_data_o),
        .line_pos_n_o(line_pos_n_o),
        .line_neg_n_o(line_neg_n_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected {pos_n, neg_n} for half-bit hh of a frame.
    function automatic logic [1:0] exp_half(input bit cmd, input logic [NB-1:0] w, input int hh);
        int  slot = hh / 2;
        bit  ph   = bit'(hh % 2);
        bit  pos;
        bit  b;
        if (slot < 3) begin
            pos = cmd ? (hh < 3) : (hh >= 3);
        end else begin
            if (slot < 3 + NB) b = w[NB - 1 - (slot - 3)];
            else               b = ~(^w);
            pos = b ^ ph;
        end
        return {~pos, pos};
    endfunction

    // Request frame 0 at a falling shift-clock edge.
    task automatic launch(input bit cmd, input bit keep_en);
        @(negedge clk);
        while (!shift_clk_o) @(negedge clk);
        enc_en_i   = 1'b1;
        sync_cmd_i = cmd;
        @(negedge clk);
        if (!keep_en) enc_en_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_frames(input int nw, input int inh_from, input int inh_to, input string tag);
        int bad_h = 0;
        int first_bad = -1;
        int got_bad = 0;
        int exp_bad = 0;
        int both_low = 0;
        int sd_cnt = 0;
        int sd_first = -1;
        int dcnt = 0;
        int idle_bad = 0;
        launch(cq[0], nw > 1);
        for (int h = 0; h < HF * nw; h++) begin
            int wi = h / HF;
            int hh = h % HF;
            logic [1:0] got;
            logic [1:0] exp;
            drive_en_i = !(h >= inh_from && h < inh_to);
            #1;
            got = {line_pos_n_o, line_neg_n_o};
            exp = drive_en_i ? exp_half(cq[wi], wq[wi], hh) : 2'b11;
            if (got != exp) begin
                bad_h++;
                if (first_bad < 0) begin
                    first_bad = h; got_bad = int'(got); exp_bad = int'(exp);
                end
            end
            if (got == 2'b00) both_low++;
            if (hh == 0) dcnt = 0;
            if (send_data_o) begin
                sd_cnt++;
                if (sd_first < 0) sd_first = hh;
            end
            // Data source: change on falling edges, scramble otherwise.
            if (!shift_clk_o && send_data_o) begin
                ser_data_i = wq[wi][NB - 1 - dcnt];
                dcnt++;
            end else if (shift_clk_o) begin
                ser_data_i = 1'($urandom);
            end
            if (hh == 1) begin
                if (wi + 1 < nw) sync_cmd_i = cq[wi + 1];
                else begin
                    enc_en_i   = 1'b0;
                    sync_cmd_i = 1'($urandom);
                end
            end
            @(negedge clk);
        end
        drive_en_i = 1'b1;
        for (int k = 0; k < 6; k++) begin
            #1;
            if (!(line_pos_n_o && line_neg_n_o && !send_data_o)) idle_bad++;
            @(negedge clk);
        end
        chk(bad_h == 0, "R3 R5 R6 R8", {tag, " half-bit mismatch at first bad index"},
            (bad_h == 0) ? 0 : (first_bad * 16 + got_bad), (bad_h == 0) ? 0 : (first_bad * 16 + exp_bad));
        chk(sd_cnt == 32 * nw, "R4", {tag, " request half-bits"}, sd_cnt, 32 * nw);
        chk(sd_first == 4, "R4", {tag, " first request half-bit"}, sd_first, 4);
        chk(both_low == 0, "R10", {tag, " both outputs low"}, both_low, 0);
        chk(idle_bad == 0, "R7", {tag, " idle after last frame"}, idle_bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int toggles;
        bit prev;
        void'($urandom(32'h5EED_1553));
        repeat (3) @(negedge clk);
        #1;
        // R9 state under reset.
        chk(line_pos_n_o && line_neg_n_o, "R9", "lines idle in reset", {line_pos_n_o, line_neg_n_o}, 3);
        chk(!send_data_o, "R9", "request low in reset", send_data_o, 0);
        chk(shift_clk_o, "R9", "shift clock high in reset", shift_clk_o, 1);
        rst = 1'b0;
        #1;
        // R1: shift clock toggles every cycle, high first.
        prev = shift_clk_o;
        chk(prev, "R1", "first shift clock level", prev, 1);
        toggles = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            #1;
            if (shift_clk_o != prev) toggles++;
            prev = shift_clk_o;
        end
        chk(toggles == 8, "R1", "shift clock toggles", toggles, 8);
        // R2: no frame without a request.
        chk(line_pos_n_o && line_neg_n_o && !send_data_o, "R2", "idle without enable",
            {line_pos_n_o, line_neg_n_o, send_data_o}, 6);

        // Directed words.
        wq[0] = '0;       cq[0] = 1'b1; run_frames(1, -1, -1, "zero word cmd");
        wq[0] = '1;       cq[0] = 1'b0; run_frames(1, -1, -1, "ones word data");
        wq[0] = 16'hA5C3; cq[0] = 1'b1; run_frames(1, 2, 17, "R8 inhibit window");
        wq[0] = 16'h8001; cq[0] = 1'b0;
        wq[1] = 16'h7FFE; cq[1] = 1'b1;
        wq[2] = 16'h0F0F; cq[2] = 1'b0; run_frames(3, -1, -1, "R7 back to back");

        // Abort in the middle of the data field.
        launch(1'b1, 1'b0);
        repeat (14) begin
            ser_data_i = 1'($urandom);
            @(negedge clk);
        end
        #1;
        chk(send_data_o, "R9", "request active before abort", send_data_o, 1);
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk(line_pos_n_o && line_neg_n_o && !send_data_o && shift_clk_o, "R9",
            "cleared by abort", {line_pos_n_o, line_neg_n_o, send_data_o, shift_clk_o}, 13);
        rst = 1'b0;
        wq[0] = 16'h1234; cq[0] = 1'b0; run_frames(1, -1, -1, "R9 after abort");

        // Random frames.
        for (int r = 0; r < 6; r++) begin
            int nw = 1 + int'($urandom_range(2));
            for (int k = 0; k < 4; k++) begin
                wq[k] = 16'($urandom);
                cq[k] = 1'($urandom);
            end
            if ((r % 2) == 1) run_frames(nw, 6 + r, 20 + 3 * r, "random inhibit");
            else              run_frames(nw, -1, -1, "random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule